// File: doc/BRIEF.md
# Block Transfer Sequencer

This block carries out the multi-word register transfers of a compact-instruction CPU, one word per memory access. The decoder hands it a transfer kind, a low-register list of eight bits, an extra-register flag, a base register number and the current base (or stack pointer) value. The sequencer then walks the list and issues 32-bit word accesses on a request/ready memory port. For stores it reads each register through a read strobe. For loads it writes each fetched word back through a write strobe. At the end it presents the updated base or stack pointer on a writeback port.

Four transfer kinds are supported. Two take an arbitrary base r0 to r7 and always count upward: the ascending load and the ascending store. The other two work on the stack pointer: pop climbs from the stack pointer, and push descends from just below it. For pop the extra flag adds a final load into the program counter. For push it adds a first store of the link register. The control is a four-state machine:
- IDLE waits for `start`.
- IDLE goes to XFER when the request has work, or straight to DONE when the list is empty.
- XFER stays put while `mem_ready` is low or while slots remain, and moves to WB when the last access completes.
- WB always moves to DONE, and DONE always returns to IDLE.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_req`, `rf_rd_en`, `rf_we` and `wb_en` are all low.
- R2: For kind 00 (ascending load) and kind 01 (ascending store), accesses start at `base_val`. They take the set bits of `reg_list` lowest index first, and the address rises by 4 per access.
- R3: An ascending store drives `wb_en` for one cycle with `wb_idx` equal to `base_idx` and `wb_data` equal to `base_val` plus 4 times the number of set bits. This happens in the cycle after the last access completes.
- R4: An ascending load writes each fetched word to its register via `rf_we`. The base is written back (value as in R3) only when bit `base_idx` of `reg_list` is clear. Otherwise `wb_en` stays low and the base register keeps the loaded word.
- R5: Kind 10 (pop) loads the listed registers lowest first, starting at `base_val`. When `extra` is set, one further word is loaded to register index 15 with bit 0 cleared.
- R6: A pop writes back register index 13 with the address just past the last word read.
- R7: Kind 11 (push) makes its first store at `base_val` minus 4, and each later store is 4 lower. When `extra` is set, register index 14 is stored first, at the highest address. The listed registers are then stored from r7 down to r0.
- R8: A push writes back register index 13 with the lowest address written.
- R9: A request with nothing to transfer makes no memory access and no writeback, and it raises `done` in the cycle after `start` is taken. Nothing to transfer means an empty list, with `extra` clear or a kind of 00 or 01.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_addr` and `mem_we` hold their values, no register strobe fires and the sequence does not advance.
- R11: `done` is a single-cycle pulse. It comes one cycle after `wb_en` when a writeback occurs, and otherwise two cycles after the last access completes.
- R12: A `start` raised while `busy` is high is ignored.
- R13: For kinds 00 and 01 the `extra` input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a transfer (taken only when idle) |
| op | input | 2 | Transfer kind: 00 ascending load, 01 ascending store, 10 pop, 11 push |
| base_idx | input | 3 | Base register number for kinds 00/01 |
| reg_list | input | 8 | Low-register list, bit n selects rn |
| extra | input | 1 | Pop: also load PC; push: also store LR |
| base_val | input | 32 | Current base or stack pointer value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data |
| mem_ready | input | 1 | Access completes this cycle |
| rf_rd_en | output | 1 | Register read strobe for stores |
| rf_rd_idx | output | 4 | Register read index |
| rf_rd_data | input | 32 | Register read data |
| rf_we | output | 1 | Register write strobe for loads |
| rf_wr_idx | output | 4 | Register write index |
| rf_wr_data | output | 32 | Register write data |
| wb_en | output | 1 | Base / stack pointer writeback strobe |
| wb_idx | output | 4 | Writeback register index |
| wb_data | output | 32 | Writeback value |

## Verification
An ascending load can target the base register both through a list bit and through the final base update. These two writes meet in one instruction and on the same register. Vectors with the base bit set and clear are run back to back. The bench judges them on whether `wb_en` appears and on which value the base register keeps afterwards. A second overlap is a fresh `start` landing while a store sequence is still stalled or running. The bench provokes it mid-transfer and requires the address sequence, the writeback and the single `done` pulse to match the first request alone.

// File: rtl/blx_pkg.sv
package blx_pkg;

    typedef enum logic [1:0] {
        OP_LDM  = 2'b00,
        OP_STM  = 2'b01,
        OP_POP  = 2'b10,
        OP_PUSH = 2'b11
    } blx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_WB,
        ST_DONE
    } blx_state_e;

    localparam int RIDX_W = 4;
    localparam int SP_IDX = 13;
    localparam int LR_IDX = 14;
    localparam int PC_IDX = 15;

endpackage

// File: rtl/blx_pick.sv
// Priority picker over the pending register mask: lowest set bit when
// ascending, highest set bit when descending.
module blx_pick #(
    parameter int NREG  = 8,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  pend,
    input  logic             desc,
    output logic [IDX_W-1:0] idx,
    output logic [NREG-1:0]  hot,
    output logic             any
);

    always_comb begin
        idx = '0;
        if (desc) begin
            for (int i = 0; i < NREG; i++) begin
                if (pend[i]) idx = IDX_W'(i);
            end
        end else begin
            for (int i = NREG - 1; i >= 0; i--) begin
                if (pend[i]) idx = IDX_W'(i);
            end
        end
    end

    assign any = |pend;
    assign hot = any ? (NREG'(1) << idx) : '0;

endmodule

// File: rtl/blx_addr.sv
// Address walker: loads the start address, steps by one word per access.
module blx_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          down,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] wb_val
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= down ? (load_val - STEP_V) : load_val;
        end else if (adv) begin
            addr <= down ? (addr - STEP_V) : (addr + STEP_V);
        end
    end

    // After the last step the pointer sits one word beyond the final access.
    assign wb_val = down ? (addr + STEP_V) : addr;

    // R2 / R7: every completed access moves the address by exactly one word
    a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (addr == ($past(down) ? ($past(addr) - STEP_V)
                                                 : ($past(addr) + STEP_V))));

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blx_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int NREG = 8,
    localparam int LIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [LIDX_W-1:0] base_idx,
    input  logic [NREG-1:0]   reg_list,
    input  logic              extra,
    input  logic [AW-1:0]     base_val,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ready,
    output logic              rf_rd_en,
    output logic [RIDX_W-1:0] rf_rd_idx,
    input  logic [DW-1:0]     rf_rd_data,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_wr_idx,
    output logic [DW-1:0]     rf_wr_data,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [AW-1:0]     wb_data
);

    localparam int STEP = DW / 8;

    blx_state_e        state, nxt;
    blx_op_e           op_in, op_q;
    logic [LIDX_W-1:0] bidx_q;
    logic [NREG-1:0]   pend_q;
    logic              xtra_q;
    logic              wb_ok_q;

    logic              is_push, is_load;
    logic              accept, has_work, step, last;
    logic              slot_xtra, slot_pc;
    logic [LIDX_W-1:0] pk_idx;
    logic [NREG-1:0]   pk_hot;
    logic              pk_any;
    logic [RIDX_W-1:0] cur_idx;
    logic              addr_down;
    logic [AW-1:0]     cur_addr, wb_val;

    assign op_in    = blx_op_e'(op);
    assign is_push  = (op_q == OP_PUSH);
    assign is_load  = (op_q == OP_LDM) || (op_q == OP_POP);
    assign accept   = (state == ST_IDLE) && start;
    assign has_work = (|reg_list) || (extra && op[1]);
    assign step     = (state == ST_XFER) && mem_ready;

    blx_pick #(.NREG(NREG), .IDX_W(LIDX_W)) u_pick (
        .pend (pend_q),
        .desc (is_push),
        .idx  (pk_idx),
        .hot  (pk_hot),
        .any  (pk_any)
    );

    // Extra slot: first for push (link register), last for pop (PC).
    assign slot_xtra = xtra_q && (is_push || !pk_any);
    assign slot_pc   = slot_xtra && !is_push;
    assign cur_idx   = slot_xtra ? (is_push ? RIDX_W'(LR_IDX) : RIDX_W'(PC_IDX))
                                 : RIDX_W'(pk_idx);
    assign last      = slot_xtra ? (pend_q == '0)
                                 : (((pend_q & ~pk_hot) == '0) && !xtra_q);

    assign addr_down = (state == ST_IDLE) ? (op_in == OP_PUSH) : is_push;

    blx_addr #(.AW(AW), .STEP(STEP)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (base_val),
        .down     (addr_down),
        .adv      (step),
        .addr     (cur_addr),
        .wb_val   (wb_val)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = has_work ? ST_XFER : ST_DONE;
            ST_XFER: if (mem_ready && last) nxt = ST_WB;
            ST_WB:   nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // Request context and remaining work
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_LDM;
            bidx_q  <= '0;
            pend_q  <= '0;
            xtra_q  <= 1'b0;
            wb_ok_q <= 1'b0;
        end else if (accept) begin
            op_q    <= op_in;
            bidx_q  <= base_idx;
            pend_q  <= reg_list;
            xtra_q  <= extra && op[1];
            wb_ok_q <= (op_in != OP_LDM) || !reg_list[base_idx];
        end else if (step) begin
            if (slot_xtra) xtra_q <= 1'b0;
            else           pend_q <= pend_q & ~pk_hot;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur_addr;
        mem_wdata  = rf_rd_data;
        rf_rd_en   = 1'b0;
        rf_rd_idx  = '0;
        rf_we      = 1'b0;
        rf_wr_idx  = '0;
        rf_wr_data = mem_rdata & {{(DW-1){1'b1}}, !slot_pc};
        wb_en      = 1'b0;
        wb_idx     = op_q[1] ? RIDX_W'(SP_IDX) : RIDX_W'(bidx_q);
        wb_data    = wb_val;
        unique case (state)
            ST_IDLE: ;
            ST_XFER: begin
                mem_req = 1'b1;
                if (is_load) begin
                    rf_we     = mem_ready;
                    rf_wr_idx = cur_idx;
                end else begin
                    mem_we    = 1'b1;
                    rf_rd_en  = 1'b1;
                    rf_rd_idx = cur_idx;
                end
            end
            ST_WB:   wb_en = wb_ok_q;
            ST_DONE: ;
        endcase
    end

    // R1: nothing moves while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_req || rf_rd_en || rf_we || wb_en));

    // R10: a stalled access holds its address and direction
    a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: program counter never receives an odd value
    a_r5_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && (rf_wr_idx == RIDX_W'(PC_IDX))) |-> !rf_wr_data[0]);

    // R11: done follows writeback by one cycle
    a_r11_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> done);

    // R11: done is a single pulse
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;

    localparam int CLK_P = 10;
    localparam int NV    = 11;

    // {op[31:30], base_idx[29:27], list[26:19], extra[18], stall[17], poke[16], base[15:0]}
    localparam logic [31:0] VEC [NV] = '{
        {2'b01, 3'd2, 8'hB5, 1'b0, 1'b0, 1'b0, 16'h0020},
        {2'b00, 3'd3, 8'h0B, 1'b0, 1'b0, 1'b0, 16'h0040},
        {2'b00, 3'd5, 8'h0B, 1'b0, 1'b0, 1'b0, 16'h0060},
        {2'b10, 3'd0, 8'h11, 1'b1, 1'b1, 1'b0, 16'h0080},
        {2'b10, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0090},
        {2'b11, 3'd0, 8'h81, 1'b1, 1'b0, 1'b0, 16'h00C0},
        {2'b11, 3'd0, 8'hFF, 1'b0, 1'b1, 1'b0, 16'h00F0},
        {2'b11, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0070},
        {2'b00, 3'd1, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0030},
        {2'b01, 3'd1, 8'h03, 1'b1, 1'b0, 1'b0, 16'h0010},
        {2'b01, 3'd0, 8'h7E, 1'b0, 1'b1, 1'b1, 16'h00A0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [2:0]  base_idx = 3'd0;
    logic [7:0]  reg_list = 8'h00;
    logic        extra = 1'b0;
    logic [31:0] base_val = 32'h0;
    logic        busy, done;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        rf_rd_en, rf_we, wb_en;
    logic [3:0]  rf_rd_idx, rf_wr_idx, wb_idx;
    logic [31:0] rf_rd_data, rf_wr_data, wb_data;

    logic [31:0] mem  [64];
    logic [31:0] regs [16];
    logic        stall_on = 1'b0;
    logic        rdy_tog = 1'b0;
    int          cyc = 0;
    int          n_tests = 0;
    int          n_fail = 0;

    // monitor state (written only by the monitor)
    logic [31:0] a_addr [256];
    logic [31:0] a_dat  [256];
    logic [3:0]  a_idx  [256];
    logic        a_we   [256];
    int          a_cyc  [256];
    int          acc_tot = 0;
    int          wb_tot = 0;
    logic [3:0]  wb_last_idx = '0;
    logic [31:0] wb_last_dat = '0;
    int          wb_cyc = 0;
    int          done_tot = 0;
    int          done_cyc = 0;
    int          stall_tot = 0;
    int          hold_bad = 0;
    logic        hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;

    always #(CLK_P/2) clk = ~clk;

    blk_xfer_seq i_blk_xfer_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op         (op),
        .base_idx   (base_idx),
        .reg_list   (reg_list),
        .extra      (extra),
        .base_val   (base_val),
        .busy       (busy),
        .done       (done),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .rf_rd_en   (rf_rd_en),
        .rf_rd_idx  (rf_rd_idx),
        .rf_rd_data (rf_rd_data),
        .rf_we      (rf_we),
        .rf_wr_idx  (rf_wr_idx),
        .rf_wr_data (rf_wr_data),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data)
    );

    assign mem_ready  = stall_on ? rdy_tog : 1'b1;
    assign mem_rdata  = mem[mem_addr[7:2]];
    assign rf_rd_data = regs[rf_rd_idx];

    initial begin
        for (int j = 0; j < 64; j++) mem[j] <= 32'h8000_0001 + 32'(j) * 32'h100;
        for (int j = 0; j < 16; j++) regs[j] <= 32'h5A00_0000 + 32'(j) * 32'h0001_0101;
    end

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rdy_tog <= !rdy_tog;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (rf_we) regs[rf_wr_idx] <= rf_wr_data;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ready) begin
                a_addr[acc_tot % 256] <= mem_addr;
                a_we[acc_tot % 256]   <= mem_we;
                a_idx[acc_tot % 256]  <= mem_we ? rf_rd_idx : rf_wr_idx;
                a_dat[acc_tot % 256]  <= mem_we ? mem_wdata : rf_wr_data;
                a_cyc[acc_tot % 256]  <= cyc;
                acc_tot <= acc_tot + 1;
            end
            if (mem_req && !mem_ready) stall_tot <= stall_tot + 1;
            if ((mem_req && !mem_ready && rf_we) ||
                (hold_pend && (!mem_req || mem_addr != hold_addr)))
                hold_bad <= hold_bad + 1;
            hold_pend <= mem_req && !mem_ready;
            hold_addr <= mem_addr;
            if (wb_en) begin
                wb_tot      <= wb_tot + 1;
                wb_last_idx <= wb_idx;
                wb_last_dat <= wb_data;
                wb_cyc      <= cyc;
            end
            if (done) begin
                done_tot <= done_tot + 1;
                done_cyc <= cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input logic [31:0] v);
        logic [1:0]  vop;
        logic [2:0]  vb;
        logic [7:0]  vl;
        logic        vx, vs, vp, empty, e_wb;
        logic [31:0] vbase, a;
        logic [31:0] e_addr [16];
        logic [31:0] e_dat  [16];
        logic [3:0]  e_idx  [16];
        logic [3:0]  e_wb_idx;
        logic [31:0] e_wb_val;
        int          e_n, acc0, wb0, done0, st_cyc, k, last_cyc;
        string       seq_tag, wb_tag;
        bit          ok;
        logic [31:0] bad_a, bad_e;

        vop = v[31:30]; vb = v[29:27]; vl = v[26:19];
        vx = v[18]; vs = v[17]; vp = v[16]; vbase = {16'h0, v[15:0]};
        e_n = 0;
        empty = (vl == 8'h00) && !(vx && vop[1]);
        // expected sequence from the requirements
        if (vop == 2'b11) begin
            a = vbase - 4;
            if (vx) begin
                e_addr[e_n] = a; e_idx[e_n] = 4'd14; e_dat[e_n] = regs[14];
                e_n++; a = a - 4;
            end
            for (int i = 7; i >= 0; i--) if (vl[i]) begin
                e_addr[e_n] = a; e_idx[e_n] = 4'(i); e_dat[e_n] = regs[i];
                e_n++; a = a - 4;
            end
            e_wb_val = a + 4;
        end else begin
            a = vbase;
            for (int i = 0; i < 8; i++) if (vl[i]) begin
                e_addr[e_n] = a; e_idx[e_n] = 4'(i);
                e_dat[e_n] = (vop == 2'b01) ? regs[i] : mem[a[7:2]];
                e_n++; a = a + 4;
            end
            if (vop == 2'b10 && vx) begin
                e_addr[e_n] = a; e_idx[e_n] = 4'd15;
                e_dat[e_n] = mem[a[7:2]] & 32'hFFFF_FFFE;
                e_n++; a = a + 4;
            end
            e_wb_val = a;
        end
        e_wb     = !empty && (vop != 2'b00 || !vl[vb]);
        e_wb_idx = vop[1] ? 4'd13 : 4'(vb);
        unique case (vop)
            2'b00: begin seq_tag = vx ? "R13" : "R2"; wb_tag = "R4"; end
            2'b01: begin seq_tag = vx ? "R13" : "R2"; wb_tag = "R3"; end
            2'b10: begin seq_tag = "R5"; wb_tag = "R6"; end
            default: begin seq_tag = "R7"; wb_tag = "R8"; end
        endcase
        if (empty) begin seq_tag = "R9"; wb_tag = "R9"; end

        @(negedge clk);
        acc0 = acc_tot; wb0 = wb_tot; done0 = done_tot; st_cyc = cyc;
        op = vop; base_idx = vb; reg_list = vl; extra = vx; base_val = vbase;
        stall_on = vs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (vp) begin
            @(negedge clk);
            @(negedge clk);
            op = 2'b11; reg_list = 8'hFF; extra = 1'b1; base_val = 32'h40;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (!done && k < 400) begin
            @(negedge clk);
            k++;
        end
        chk(k < 400, "R11", "watchdog on done", 32'(k), 32'd400);
        @(negedge clk);
        @(negedge clk);
        stall_on = 1'b0;

        chk(acc_tot - acc0 == e_n, seq_tag, "access count", 32'(acc_tot - acc0), 32'(e_n));
        ok = 1'b1; bad_a = '0; bad_e = '0;
        for (int i = 0; i < e_n && i < acc_tot - acc0; i++) begin
            if (ok && (a_addr[(acc0 + i) % 256] != e_addr[i] ||
                       a_idx[(acc0 + i) % 256] != e_idx[i] ||
                       a_dat[(acc0 + i) % 256] != e_dat[i] ||
                       a_we[(acc0 + i) % 256] != (vop == 2'b01 || vop == 2'b11))) begin
                ok = 1'b0;
                bad_a = {a_addr[(acc0 + i) % 256][15:0], 4'h0, a_idx[(acc0 + i) % 256],
                         8'(a_dat[(acc0 + i) % 256])};
                bad_e = {e_addr[i][15:0], 4'h0, e_idx[i], 8'(e_dat[i])};
            end
        end
        chk(ok, seq_tag, "addr/idx/data sequence", bad_a, bad_e);

        chk(wb_tot - wb0 == (e_wb ? 1 : 0), wb_tag, "writeback count",
            32'(wb_tot - wb0), e_wb ? 32'd1 : 32'd0);
        if (e_wb) begin
            chk(wb_last_idx == e_wb_idx && wb_last_dat == e_wb_val, wb_tag,
                "writeback idx/value", {wb_last_idx, wb_last_dat[27:0]},
                {e_wb_idx, e_wb_val[27:0]});
        end

        if (vop == 2'b00 || vop == 2'b10) begin
            ok = 1'b1;
            for (int i = 0; i < e_n; i++) if (regs[e_idx[i]] != e_dat[i]) ok = 1'b0;
            chk(ok, (vop == 2'b00) ? "R4" : "R5", "loaded registers", 32'(ok), 32'd1);
        end

        chk(done_tot - done0 == 1, "R11", "done pulse count", 32'(done_tot - done0), 32'd1);
        if (empty) begin
            chk(done_cyc == st_cyc + 1, "R9", "done timing when empty",
                32'(done_cyc - st_cyc), 32'd1);
        end else if (e_wb) begin
            chk(done_cyc == wb_cyc + 1, "R11", "done after writeback",
                32'(done_cyc - wb_cyc), 32'd1);
        end else begin
            last_cyc = a_cyc[(acc_tot - 1) % 256];
            chk(done_cyc == last_cyc + 2, "R11", "done after last access",
                32'(done_cyc - last_cyc), 32'd2);
        end

        if (vs) begin
            chk(stall_tot > 0 && hold_bad == 0, "R10", "stall hold",
                32'(hold_bad), 32'd0);
        end
        if (vp) begin
            acc0 = acc_tot;
            repeat (4) @(negedge clk);
            chk(acc_tot == acc0 && !busy, "R12", "no second run after busy start",
                32'(acc_tot - acc0), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && !rf_rd_en && !rf_we && !wb_en, "R1",
            "outputs in reset", {26'h0, busy, done, mem_req, rf_rd_en, rf_we, wb_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !wb_en, "R1", "idle after reset",
            {28'h0, busy, done, mem_req, wb_en}, 32'h0);
        for (int n = 0; n < NV; n++) run_vec(VEC[n]);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL R11 global watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule